// File: doc/BRIEF.md
# Windowed Command and Status Register Unit

This block sits between a host register bus and the engines of a network controller. Software writes 16-bit command words to a single port. The top five bits hold an opcode and the low eleven bits hold a parameter. Reading the same location returns a status word. That word carries the latched event flags, the summary interrupt bit, a busy flag and the number of the register window currently in view. The window number is a 3-bit value that software chooses. Neighbouring address decoders use it to pick which of eight register banks appears at the low offsets.

Event pulses from the transmit, receive and DMA engines are latched only when the indication mask passes them. A separate interrupt mask decides which latched flags drive the interrupt line. The reset commands keep the busy flag high for a fixed number of cycles. During that time they assert a level request to the engine being reset. When the busy flag drops, they pulse a done strobe to that engine. The unit also keeps transmit and receive enable levels and a download-stall level.

Top module: `cmd_status_regs`

## Requirements
- R1: After reset every output is zero, and the status word reads 0x0000.
- R2: Opcode 0x01 loads the window number from parameter bits 2:0. The window number appears on `window_o` and in status bits 15:13.
- R3: Three opcodes are reset commands: 0x0B (transmit), 0x05 (receive) and 0x00 (global). Each one sets status bit 12 for exactly RST_CYCLES cycles. During that time it drives the matching reset request: `tx_rst_o`, `rx_rst_o`, or both for global reset. In the first cycle after bit 12 falls, it pulses the matching done strobe high for one cycle.
- R4: A command written while status bit 12 is set has no effect.
- R5: Event inputs map to status bits as follows: 1 host error, 2 tx complete, 4 rx complete, 5 rx early, 6 interrupt requested, 7 update statistics, 8 link event, 9 download complete, 10 upload complete. An event latches only if its bit is set in the indication mask, which opcode 0x0F loads from the parameter.
- R6: Opcode 0x0D clears each latched bit that is set in its parameter. If an event arrives in the same cycle as the clear, the event wins and the bit stays set.
- R7: Opcode 0x0E loads the interrupt mask. Status bit 0 and `irq_o` are high exactly when some latched bit is also interrupt-enabled.
- R8: Opcode 0x09 sets the transmit enable and 0x0A clears it. Opcode 0x04 sets the receive enable and 0x03 clears it. A reset command clears the enable of the side it resets.
- R9: Opcode 0x06 with parameter 2 sets `dn_stall_o`, and with parameter 3 clears it. Any other parameter leaves it unchanged.
- R10: Global reset (0x00) clears the window, both masks, all latched bits, both enables and the stall. It also pulses `station_clr_o` for one cycle.
- R11: Status bits 3 and 11 always read zero. Event inputs 0 and 3 are ignored, and opcodes not listed above have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 16 | Command word: opcode 15:11, parameter 10:0 |
| ev_i | input | 11 | Event pulses, indexed by status bit |
| status_o | output | 16 | Status word |
| window_o | output | 3 | Selected register window |
| irq_o | output | 1 | Interrupt line |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Receive enable |
| dn_stall_o | output | 1 | Download engine stall |
| tx_rst_o | output | 1 | Transmit reset request, held while busy |
| rx_rst_o | output | 1 | Receive reset request, held while busy |
| tx_done_o | output | 1 | One-cycle pulse when a transmit reset ends |
| rx_done_o | output | 1 | One-cycle pulse when a receive reset ends |
| station_clr_o | output | 1 | One-cycle pulse to clear the station mask |

## Verification
The acknowledge command and a new event can target the same latched bit in one clock edge. The bench provokes this by driving an rx-complete pulse in the same cycle as an acknowledge of that bit. It then expects bit 4 to remain set, and expects a later acknowledge on its own to clear it. A second collision is a command written while a reset holds the busy flag. The bench issues a window select during a transmit reset and checks that the window number is unchanged after the done strobe.

// File: rtl/cmd_status_regs.sv
module cmd_status_regs #(
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic [10:0] ev_i,
  output logic [15:0] status_o,
  output logic [2:0]  window_o,
  output logic        irq_o,
  output logic        tx_en_o,
  output logic        rx_en_o,
  output logic        dn_stall_o,
  output logic        tx_rst_o,
  output logic        rx_rst_o,
  output logic        tx_done_o,
  output logic        rx_done_o,
  output logic        station_clr_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [10:0] EVMASK = 11'h7F6;

  localparam logic [4:0] OP_GRST   = 5'h00;
  localparam logic [4:0] OP_WIN    = 5'h01;
  localparam logic [4:0] OP_RXOFF  = 5'h03;
  localparam logic [4:0] OP_RXON   = 5'h04;
  localparam logic [4:0] OP_RXRST  = 5'h05;
  localparam logic [4:0] OP_STALL  = 5'h06;
  localparam logic [4:0] OP_TXON   = 5'h09;
  localparam logic [4:0] OP_TXOFF  = 5'h0A;
  localparam logic [4:0] OP_TXRST  = 5'h0B;
  localparam logic [4:0] OP_ACK    = 5'h0D;
  localparam logic [4:0] OP_INTEN  = 5'h0E;
  localparam logic [4:0] OP_INDEN  = 5'h0F;

  logic [2:0]    win_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    tgt_q;
  logic [10:0]   lat_q, int_en_q, ind_en_q;

  wire [4:0]  op  = wr_data[15:11];
  wire [10:0] prm = wr_data[10:0];
  wire        acc = wr_en & ~busy_q;
  wire [10:0] ev_set  = ev_i & ind_en_q & EVMASK;
  wire [10:0] ack_clr = (acc && op == OP_ACK) ? (prm & EVMASK) : 11'h0;

  assign irq_o      = |(lat_q & int_en_q & EVMASK);
  assign window_o   = win_q;
  assign tx_rst_o   = busy_q & tgt_q[0];
  assign rx_rst_o   = busy_q & tgt_q[1];
  assign status_o   = {win_q, busy_q, 1'b0, lat_q[10:4], 1'b0, lat_q[2:1], irq_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q         <= '0;
      busy_q        <= 1'b0;
      cnt_q         <= '0;
      tgt_q         <= '0;
      lat_q         <= '0;
      int_en_q      <= '0;
      ind_en_q      <= '0;
      tx_en_o       <= 1'b0;
      rx_en_o       <= 1'b0;
      dn_stall_o    <= 1'b0;
      tx_done_o     <= 1'b0;
      rx_done_o     <= 1'b0;
      station_clr_o <= 1'b0;
    end else begin
      tx_done_o     <= 1'b0;
      rx_done_o     <= 1'b0;
      station_clr_o <= 1'b0;
      lat_q         <= (lat_q & ~ack_clr) | ev_set;

      if (busy_q) begin
        if (cnt_q == CW'(1)) begin
          busy_q    <= 1'b0;
          tx_done_o <= tgt_q[0];
          rx_done_o <= tgt_q[1];
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end

      if (acc) begin
        case (op)
          OP_GRST: begin
            busy_q        <= 1'b1;
            cnt_q         <= CW'(RST_CYCLES);
            tgt_q         <= 2'b11;
            win_q         <= '0;
            lat_q         <= '0;
            int_en_q      <= '0;
            ind_en_q      <= '0;
            tx_en_o       <= 1'b0;
            rx_en_o       <= 1'b0;
            dn_stall_o    <= 1'b0;
            station_clr_o <= 1'b1;
          end
          OP_WIN:   win_q   <= prm[2:0];
          OP_RXOFF: rx_en_o <= 1'b0;
          OP_RXON:  rx_en_o <= 1'b1;
          OP_RXRST: begin
            busy_q  <= 1'b1;
            cnt_q   <= CW'(RST_CYCLES);
            tgt_q   <= 2'b10;
            rx_en_o <= 1'b0;
          end
          OP_STALL: begin
            if (prm == 11'd2)      dn_stall_o <= 1'b1;
            else if (prm == 11'd3) dn_stall_o <= 1'b0;
          end
          OP_TXON:  tx_en_o <= 1'b1;
          OP_TXOFF: tx_en_o <= 1'b0;
          OP_TXRST: begin
            busy_q  <= 1'b1;
            cnt_q   <= CW'(RST_CYCLES);
            tgt_q   <= 2'b01;
            tx_en_o <= 1'b0;
          end
          OP_INTEN: int_en_q <= prm;
          OP_INDEN: ind_en_q <= prm;
          default: ;
        endcase
      end
    end
  end

  AST_WIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_WIN) |=> (window_o == $past(wr_data[2:0]))); // R2
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_o || rx_done_o) |-> ($past(busy_q) && !busy_q)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_o |=> !tx_done_o); // R3
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_en) |=> $stable(window_o)); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_ACK) |=> ((lat_q & $past(prm & EVMASK & ~(ev_i & ind_en_q))) == 11'h0)); // R6
  AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o[10:1] != 10'h0)); // R7
  AST_STATION_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    station_clr_o |-> $past(acc && op == OP_GRST)); // R10
endmodule

// File: tb/sim_cmd_status_regs.sv
module sim_cmd_status_regs;
  localparam int CLK_PERIOD = 10;
  localparam int RSTC = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [10:0] ev_i = '0;
  logic [15:0] status_o;
  logic [2:0]  window_o;
  logic irq_o, tx_en_o, rx_en_o, dn_stall_o, tx_rst_o, rx_rst_o;
  logic tx_done_o, rx_done_o, station_clr_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_status_regs #(.RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ev_i(ev_i),
    .status_o(status_o), .window_o(window_o), .irq_o(irq_o),
    .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .dn_stall_o(dn_stall_o),
    .tx_rst_o(tx_rst_o), .rx_rst_o(rx_rst_o), .tx_done_o(tx_done_o),
    .rx_done_o(rx_done_o), .station_clr_o(station_clr_o));

  // {command, window, tx_en, rx_en, stall}
  localparam int NV = 11;
  localparam logic [21:0] VEC [NV] = '{
    {16'h0805, 3'd5, 1'b0, 1'b0, 1'b0},
    {16'h4800, 3'd5, 1'b1, 1'b0, 1'b0},
    {16'h2000, 3'd5, 1'b1, 1'b1, 1'b0},
    {16'h3002, 3'd5, 1'b1, 1'b1, 1'b1},
    {16'h3005, 3'd5, 1'b1, 1'b1, 1'b1},
    {16'h3003, 3'd5, 1'b1, 1'b1, 1'b0},
    {16'h080F, 3'd7, 1'b1, 1'b1, 1'b0},
    {16'h5000, 3'd7, 1'b0, 1'b1, 1'b0},
    {16'h1800, 3'd7, 1'b0, 1'b0, 1'b0},
    {16'hF812, 3'd7, 1'b0, 1'b0, 1'b0},
    {16'h0802, 3'd2, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] c);
    @(negedge clk); wr_en = 1'b1; wr_data = c;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [10:0] e);
    @(negedge clk); ev_i = e;
    @(negedge clk); ev_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", status_o, 16'h0000);
    chk("R1 outputs", {irq_o, tx_en_o, rx_en_o, dn_stall_o, tx_rst_o, rx_rst_o,
        tx_done_o, rx_done_o, station_clr_o, window_o}, 0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][21:6]);
      chk("R2 window", window_o, VEC[i][5:3]);
      chk("R2 status window", status_o[15:13], VEC[i][5:3]);
      chk("R8 R9 R11 levels", {tx_en_o, rx_en_o, dn_stall_o}, VEC[i][2:0]);
    end

    // R3 transmit reset, R8 clears tx enable, R4 write during busy
    issue(16'h4800);
    issue(16'h5800);
    chk("R8 tx_en cleared", tx_en_o, 1'b0);
    for (int k = 0; k < RSTC; k++) begin
      chk("R3 busy", {status_o[12], tx_rst_o, rx_rst_o}, 3'b110);
      if (k == 0) begin
        wr_en = 1'b1; wr_data = 16'h0806;
      end
      @(negedge clk);
      wr_en = 1'b0;
    end
    chk("R3 tx done", {status_o[12], tx_done_o, rx_done_o}, 3'b010);
    chk("R4 ignored while busy", window_o, 3'd2);
    @(negedge clk);
    chk("R3 done one cycle", tx_done_o, 1'b0);

    // R3 receive reset
    issue(16'h2000);
    issue(16'h2800);
    chk("R8 rx_en cleared", rx_en_o, 1'b0);
    for (int k = 0; k < RSTC; k++) begin
      chk("R3 rx busy", {status_o[12], tx_rst_o, rx_rst_o}, 3'b101);
      @(negedge clk);
    end
    chk("R3 rx done", {status_o[12], tx_done_o, rx_done_o}, 3'b001);

    // R5 indication mask
    issue(16'h7814);
    pulse(11'h104);
    chk("R5 masked latch", status_o, 16'h4004);
    issue(16'h7FFF);
    pulse(11'h100);
    chk("R5 link latched", status_o[10:0], 11'h104);
    chk("R7 irq off", irq_o, 1'b0);
    issue(16'h7100);
    chk("R7 irq on", {irq_o, status_o[0]}, 2'b11);
    issue(16'h6900);
    chk("R6 ack clears", status_o[10:0], 11'h004);
    chk("R7 irq clears", irq_o, 1'b0);

    // R6 event wins over ack in same cycle
    @(negedge clk); ev_i = 11'h010; wr_en = 1'b1; wr_data = 16'h6810;
    @(negedge clk); ev_i = '0; wr_en = 1'b0;
    chk("R6 event wins", status_o[4], 1'b1);
    issue(16'h6810);
    chk("R6 ack alone", status_o[4], 1'b0);

    // R11 reserved bits
    pulse(11'h7FF);
    chk("R11 zero bits", {status_o[11], status_o[3]}, 2'b00);
    chk("R11 all events", status_o[10:1], 10'h3FB);

    // R10 global reset
    issue(16'h4800);
    issue(16'h3002);
    issue(16'h0000);
    chk("R10 station pulse", station_clr_o, 1'b1);
    chk("R10 cleared", {status_o[15:13], status_o[11:0], tx_en_o, rx_en_o, dn_stall_o}, 0);
    chk("R3 global busy", {status_o[12], tx_rst_o, rx_rst_o}, 3'b111);
    @(negedge clk);
    chk("R10 station one cycle", station_clr_o, 1'b0);
    repeat (RSTC - 1) @(negedge clk);
    chk("R3 global done", {status_o[12], tx_done_o, rx_done_o}, 3'b011);
    pulse(11'h004);
    chk("R10 ind mask cleared", status_o, 16'h0000);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule